// File: doc/BRIEF.md
# Two-Clock Shared-Array Memory with Per-Port Shape

A synchronous memory of 18432 bits reached through two fully independent ports, A and B. Each port has its own clock, output reset, enable, write enables, address, write data and read data. The only thing the ports share is the stored array. The array is organised as 2048 lanes of 9 bits. A narrow port (1, 2 or 4 bits) reaches only the low 8 bits of each lane. A wide port (9, 18 or 36 bits) covers one, two or four whole lanes per word.

Each port fixes three things at elaboration time: its data width, its write-cycle output behaviour and whether a second output register is present. The code for the output behaviour is 0 for new data, 1 for old data and 2 for hold. Wide ports of two or four lanes take one write enable per lane. The read data stays in a register and changes only when that port performs an enabled access or is reset.

Top module: `dual_port_ram18k`

## Requirements
- R1: Both ports address the same storage. Every bit reads as zero before its first write, and a word written on one port reads back at the other port.
- R2: A port of width W in {1,2,4} has 16384/W addresses. A port of width W in {9,18,36} has 18432/W addresses. The last address of each port maps to lane 2047.
- R3: On a wide port with L = W/9 lanes per word, address n covers lanes n*L to n*L+L-1. Lane n*L+k appears on data bits [9k+8:9k].
- R4: On a narrow port, address n selects lane n/(8/W) at bits [(n mod (8/W))*W +: W]. Bit 8 of each lane is never read or changed by a narrow port.
- R5: A write completes on one clock edge. Without the extra stage, read data for the address presented at an enabled edge appears right after that edge.
- R6: With output code 0 (new data), the output after a write shows the word as stored after that write. Lanes whose enable is low show their existing contents.
- R7: With output code 1 (old data), the output after a write shows the contents from before that write.
- R8: With output code 2 (hold), a write leaves the output unchanged.
- R9: While a port's enable is low, that port neither writes nor changes its output.
- R10: A port of 18 or 36 bits has one write enable per lane. Enable bit k gates data bits [9k+8:9k]. Every other width has a single write enable bit.
- R11: With the extra stage selected, read latency grows by one cycle. The extra stage advances only on edges where the port enable is high.
- R12: A high reset at a clock edge clears the port's output registers to zero, whatever the enable. Reset leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk | input | 1 | Port A clock |
| a_rst | input | 1 | Port A synchronous output reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | A_LN | Port A write enables, one per lane on 18/36-bit ports |
| a_addr | input | A_AW | Port A word address |
| a_din | input | A_W | Port A write data |
| a_dout | output | A_W | Port A read data |
| b_clk | input | 1 | Port B clock |
| b_rst | input | 1 | Port B synchronous output reset |
| b_en | input | 1 | Port B access enable |
| b_we | input | B_LN | Port B write enables, one per lane on 18/36-bit ports |
| b_addr | input | B_AW | Port B word address |
| b_din | input | B_W | Port B write data |
| b_dout | output | B_W | Port B read data |

## Verification
Suppose a lane index, a bank combination or a narrow bit offset were computed wrongly inside the block. The corrupted word would appear on the next enabled read of that location, one edge later or two edges later with the extra stage, and most clearly on the port that did not write it. A wrong write-cycle output choice shows on the very edge of the write. A fault in the extra stage's enable shows as data arriving a cycle early, or as the output moving while the enable is low. Reading the whole array back through both ports in every width used exposes any address or lane mapping error within one sweep.

// File: rtl/dual_port_ram18k.sv
module dual_port_ram18k #(
  parameter int A_W    = 36,
  parameter int A_MODE = 1,
  parameter int A_PIPE = 0,
  parameter int B_W    = 9,
  parameter int B_MODE = 0,
  parameter int B_PIPE = 0,
  localparam int A_LN = (A_W >= 9) ? A_W / 9 : 1,
  localparam int A_AW = $clog2((A_W >= 9) ? 2048 / A_LN : 16384 / A_W),
  localparam int B_LN = (B_W >= 9) ? B_W / 9 : 1,
  localparam int B_AW = $clog2((B_W >= 9) ? 2048 / B_LN : 16384 / B_W)
) (
  input  logic             a_clk,
  input  logic             a_rst,
  input  logic             a_en,
  input  logic [A_LN-1:0]  a_we,
  input  logic [A_AW-1:0]  a_addr,
  input  logic [A_W-1:0]   a_din,
  output logic [A_W-1:0]   a_dout,
  input  logic             b_clk,
  input  logic             b_rst,
  input  logic             b_en,
  input  logic [B_LN-1:0]  b_we,
  input  logic [B_AW-1:0]  b_addr,
  input  logic [B_W-1:0]   b_din,
  output logic [B_W-1:0]   b_dout
);
  localparam int LANES = 2048;
  localparam int LW    = 9;
  localparam int IW    = $clog2(LANES);
  localparam int A_NAR = (A_W < LW) ? 1 : 0;
  localparam int B_NAR = (B_W < LW) ? 1 : 0;
  localparam int A_SB  = (A_NAR != 0) ? $clog2(8 / A_W) : 0;
  localparam int B_SB  = (B_NAR != 0) ? $clog2(8 / B_W) : 0;
  localparam int A_RW  = LW * A_LN;
  localparam int B_RW  = LW * B_LN;

  // each bank has a single writer; a lane reads as the xor of both banks
  bit [LW-1:0] bank_a [LANES];
  bit [LW-1:0] bank_b [LANES];

  logic [IW-1:0]   a_base, b_base;
  logic [IW-1:0]   a_idx [A_LN];
  logic [IW-1:0]   b_idx [B_LN];
  logic [A_RW-1:0] a_old, a_mrg;
  logic [B_RW-1:0] b_old, b_mrg;
  logic [A_W-1:0]  a_rdw, a_nww, a_lat;
  logic [B_W-1:0]  b_rdw, b_nww, b_lat;
  logic            a_wr, b_wr;

  assign a_wr = a_en && (|a_we);
  assign b_wr = b_en && (|b_we);

  // ---------------- port A ----------------
  for (genvar k = 0; k < A_LN; k++) begin : g_a_ln
    assign a_idx[k] = a_base + IW'(k);
    assign a_old[LW*k +: LW] = bank_a[a_idx[k]] ^ bank_b[a_idx[k]];
  end

  if (A_NAR != 0) begin : g_a_nar
    logic [2:0] a_bo;
    assign a_base = IW'(a_addr >> A_SB);
    assign a_bo   = 3'(a_addr[A_SB-1:0] * A_W);
    always_comb begin
      a_mrg = a_old;
      a_mrg[a_bo +: A_W] = a_din;
    end
    assign a_rdw = a_old[a_bo +: A_W];
    assign a_nww = a_din;
  end else begin : g_a_wide
    assign a_base = IW'(a_addr * A_LN);
    for (genvar k = 0; k < A_LN; k++) begin : g_a_mrg
      assign a_mrg[LW*k +: LW] = a_we[k] ? a_din[LW*k +: LW] : a_old[LW*k +: LW];
    end
    assign a_rdw = a_old;
    assign a_nww = a_mrg;
  end

  always_ff @(posedge a_clk)
    if (a_wr)
      for (int k = 0; k < A_LN; k++)
        if (a_we[k]) bank_a[a_idx[k]] <= a_mrg[LW*k +: LW] ^ bank_b[a_idx[k]];

  always_ff @(posedge a_clk)
    if (a_rst)                   a_lat <= '0;
    else if (a_en) begin
      if (!a_wr || A_MODE == 1)  a_lat <= a_rdw;
      else if (A_MODE == 0)      a_lat <= a_nww;
    end

  if (A_PIPE != 0) begin : g_a_pipe
    logic [A_W-1:0] a_q;
    always_ff @(posedge a_clk)
      if (a_rst)      a_q <= '0;
      else if (a_en)  a_q <= a_lat;
    assign a_dout = a_q;
  end else begin : g_a_flat
    assign a_dout = a_lat;
  end

  // ---------------- port B ----------------
  for (genvar k = 0; k < B_LN; k++) begin : g_b_ln
    assign b_idx[k] = b_base + IW'(k);
    assign b_old[LW*k +: LW] = bank_a[b_idx[k]] ^ bank_b[b_idx[k]];
  end

  if (B_NAR != 0) begin : g_b_nar
    logic [2:0] b_bo;
    assign b_base = IW'(b_addr >> B_SB);
    assign b_bo   = 3'(b_addr[B_SB-1:0] * B_W);
    always_comb begin
      b_mrg = b_old;
      b_mrg[b_bo +: B_W] = b_din;
    end
    assign b_rdw = b_old[b_bo +: B_W];
    assign b_nww = b_din;
  end else begin : g_b_wide
    assign b_base = IW'(b_addr * B_LN);
    for (genvar k = 0; k < B_LN; k++) begin : g_b_mrg
      assign b_mrg[LW*k +: LW] = b_we[k] ? b_din[LW*k +: LW] : b_old[LW*k +: LW];
    end
    assign b_rdw = b_old;
    assign b_nww = b_mrg;
  end

  always_ff @(posedge b_clk)
    if (b_wr)
      for (int k = 0; k < B_LN; k++)
        if (b_we[k]) bank_b[b_idx[k]] <= b_mrg[LW*k +: LW] ^ bank_a[b_idx[k]];

  always_ff @(posedge b_clk)
    if (b_rst)                   b_lat <= '0;
    else if (b_en) begin
      if (!b_wr || B_MODE == 1)  b_lat <= b_rdw;
      else if (B_MODE == 0)      b_lat <= b_nww;
    end

  if (B_PIPE != 0) begin : g_b_pipe
    logic [B_W-1:0] b_q;
    always_ff @(posedge b_clk)
      if (b_rst)      b_q <= '0;
      else if (b_en)  b_q <= b_lat;
    assign b_dout = b_q;
  end else begin : g_b_flat
    assign b_dout = b_lat;
  end
endmodule

// File: rtl/dual_port_ram18k_check.sv
module dual_port_ram18k_check #(
  parameter int A_W    = 36,
  parameter int A_MODE = 1,
  parameter int A_PIPE = 0,
  parameter int B_W    = 9,
  parameter int B_MODE = 0,
  parameter int B_PIPE = 0,
  localparam int A_LN = (A_W >= 9) ? A_W / 9 : 1,
  localparam int B_LN = (B_W >= 9) ? B_W / 9 : 1
) (
  input logic            a_clk,
  input logic            a_rst,
  input logic            a_en,
  input logic [A_LN-1:0] a_we,
  input logic [A_W-1:0]  a_din,
  input logic [A_W-1:0]  a_dout,
  input logic            b_clk,
  input logic            b_rst,
  input logic            b_en,
  input logic [B_LN-1:0] b_we,
  input logic [B_W-1:0]  b_din,
  input logic [B_W-1:0]  b_dout
);
  AST_A_RESET_CLEARS: assert property (@(posedge a_clk) a_rst |=> a_dout == '0); // R12
  AST_B_RESET_CLEARS: assert property (@(posedge b_clk) b_rst |=> b_dout == '0); // R12

  AST_A_IDLE_HOLDS: assert property (@(posedge a_clk) disable iff (a_rst)
    !a_en |=> $stable(a_dout)); // R9
  AST_B_IDLE_HOLDS: assert property (@(posedge b_clk) disable iff (b_rst)
    !b_en |=> $stable(b_dout)); // R9

  AST_A_WRITE_VIEW: assert property (@(posedge a_clk) disable iff (a_rst)
    (A_PIPE == 0 && A_MODE != 1 && a_en && (&a_we)) |=>
      ((A_MODE == 0) ? (a_dout == $past(a_din)) : $stable(a_dout))); // R6 R8
  AST_B_WRITE_VIEW: assert property (@(posedge b_clk) disable iff (b_rst)
    (B_PIPE == 0 && B_MODE != 1 && b_en && (&b_we)) |=>
      ((B_MODE == 0) ? (b_dout == $past(b_din)) : $stable(b_dout))); // R6 R8
endmodule

bind dual_port_ram18k dual_port_ram18k_check #(
  .A_W(A_W), .A_MODE(A_MODE), .A_PIPE(A_PIPE),
  .B_W(B_W), .B_MODE(B_MODE), .B_PIPE(B_PIPE)
) u_check (
  .a_clk(a_clk), .a_rst(a_rst), .a_en(a_en), .a_we(a_we), .a_din(a_din), .a_dout(a_dout),
  .b_clk(b_clk), .b_rst(b_rst), .b_en(b_en), .b_we(b_we), .b_din(b_din), .b_dout(b_dout)
);

// File: tb/dual_port_ram18k_bench.sv
module dual_port_ram18k_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // unit 1: A 36-bit old-data, B 9-bit new-data, no extra stage
  logic        ar1, ae1, br1, be1;
  logic [3:0]  aw1;
  logic [0:0]  bw1;
  logic [8:0]  aa1, bd1, bq1;
  logic [10:0] ba1;
  logic [35:0] ad1, aq1;
  // unit 2: A 2-bit hold, B 18-bit old-data with extra stage
  logic        ar2, ae2, br2, be2;
  logic [0:0]  aw2;
  logic [1:0]  bw2;
  logic [12:0] aa2;
  logic [1:0]  ad2, aq2;
  logic [9:0]  ba2;
  logic [17:0] bd2, bq2;

  bit [8:0] m1 [2048];
  bit [8:0] m2 [2048];

  dual_port_ram18k u_dual_port_ram18k (
    .a_clk(clk), .a_rst(ar1), .a_en(ae1), .a_we(aw1), .a_addr(aa1), .a_din(ad1), .a_dout(aq1),
    .b_clk(clk), .b_rst(br1), .b_en(be1), .b_we(bw1), .b_addr(ba1), .b_din(bd1), .b_dout(bq1));

  dual_port_ram18k #(.A_W(2), .A_MODE(2), .A_PIPE(0), .B_W(18), .B_MODE(1), .B_PIPE(1))
  u_dual_port_ram18k_n (
    .a_clk(clk), .a_rst(ar2), .a_en(ae2), .a_we(aw2), .a_addr(aa2), .a_din(ad2), .a_dout(aq2),
    .b_clk(clk), .b_rst(br2), .b_en(be2), .b_we(bw2), .b_addr(ba2), .b_din(bd2), .b_dout(bq2));

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] w36(int i);
    return {m1[4*i+3], m1[4*i+2], m1[4*i+1], m1[4*i]};
  endfunction
  function automatic logic [17:0] w18(int j);
    return {m2[2*j+1], m2[2*j]};
  endfunction
  function automatic logic [1:0] nar(int n);
    logic [8:0] l;
    l = m2[n/4];
    return l[(n%4)*2 +: 2];
  endfunction
  function automatic logic [35:0] pat(int i);
    return {9'(i*5+1), 9'(i*3+2), 9'(i ^ 'h155), 9'(i+7)};
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [17:0] pend, oldw, held;
    ar1 = 1; ae1 = 0; aw1 = 0; aa1 = 0; ad1 = 0; br1 = 1; be1 = 0; bw1 = 0; ba1 = 0; bd1 = 0;
    ar2 = 1; ae2 = 0; aw2 = 0; aa2 = 0; ad2 = 0; br2 = 1; be2 = 0; bw2 = 0; ba2 = 0; bd2 = 0;
    repeat (3) @(negedge clk);
    chk("R12 reset clears A", aq1, '0);
    chk("R12 reset clears B", bq1, '0);
    chk("R12 reset clears stage", bq2, '0);
    ar1 = 0; br1 = 0; ar2 = 0; br2 = 0;

    // ---- unit 1 ----
    for (int i = 0; i < 512; i++) begin
      ae1 = 1; aw1 = 4'hf; aa1 = 9'(i); ad1 = pat(i);
      @(negedge clk);
      chk("R7 old data on write (R1 zero start)", aq1, w36(i));
      for (int k = 0; k < 4; k++) m1[4*i+k] = ad1[9*k +: 9];
    end
    ae1 = 0; aw1 = 0;
    for (int j = 0; j < 2048; j++) begin
      be1 = 1; bw1 = 0; ba1 = 11'(j);
      @(negedge clk);
      chk("R3 lane placement seen by 9-bit port", bq1, m1[j]);
    end
    for (int j = 0; j < 2048; j++) begin
      bw1 = 1; ba1 = 11'(j); bd1 = 9'(j*11+3);
      @(negedge clk);
      chk("R6 new data on write", bq1, bd1);
      m1[j] = bd1;
    end
    be1 = 0; bw1 = 0;
    for (int i = 0; i < 512; i++) begin
      ae1 = 1; aa1 = 9'(i);
      @(negedge clk);
      chk("R1 cross-port readback", aq1, w36(i));
    end
    chk("R2 last 36-bit word", aq1, {m1[2047], m1[2046], m1[2045], m1[2044]});
    aa1 = 5; aw1 = 4'b0101; ad1 = '1;
    @(negedge clk);
    chk("R7 old data on lane write", aq1, w36(5));
    m1[20] = '1; m1[22] = '1;
    aw1 = 0;
    @(negedge clk);
    chk("R10 lanes 0 and 2 only", aq1, w36(5));
    aa1 = 9; aw1 = 4'hf; ad1 = 36'h1_2345_6789;
    @(negedge clk);
    for (int k = 0; k < 4; k++) m1[36+k] = ad1[9*k +: 9];
    aw1 = 0;
    @(negedge clk);
    chk("R5 single-edge write", aq1, 36'h1_2345_6789);
    aa1 = 7;
    @(negedge clk);
    ae1 = 0; aw1 = 4'hf; aa1 = 8; ad1 = 36'h0_DEAD_BEEF;
    repeat (2) @(negedge clk);
    chk("R9 A output holds when disabled", aq1, w36(7));
    ae1 = 1; aw1 = 0;
    @(negedge clk);
    chk("R9 A no write when disabled", aq1, w36(8));
    be1 = 1; bw1 = 0; ba1 = 100;
    @(negedge clk);
    be1 = 0; bw1 = 1; bd1 = ~m1[100];
    repeat (2) @(negedge clk);
    chk("R9 B output holds when disabled", bq1, m1[100]);
    be1 = 1; bw1 = 0;
    @(negedge clk);
    chk("R9 B no write when disabled", bq1, m1[100]);
    be1 = 0; ae1 = 0; ar1 = 1;
    @(negedge clk);
    chk("R12 reset without enable", aq1, '0);
    ar1 = 0; ae1 = 1; aa1 = 5;
    @(negedge clk);
    chk("R12 array kept through reset", aq1, w36(5));
    ae1 = 0;

    // ---- unit 2 ----
    for (int pass = 0; pass < 2; pass++) begin
      pend = '0;
      for (int j = 0; j < 1024; j++) begin
        be2 = 1; bw2 = 2'b11; ba2 = 10'(j);
        bd2 = (pass == 0) ? 18'(j*37+5) : 18'((j*91) ^ 'h2A5A5);
        oldw = w18(j);
        @(negedge clk);
        if (j > 0) chk("R11 R7 old data one stage late", bq2, pend);
        pend = oldw;
        m2[2*j] = bd2[8:0]; m2[2*j+1] = bd2[17:9];
      end
      bw2 = 0;
      @(negedge clk);
      chk("R11 R7 last old data", bq2, pend);
    end
    ba2 = 3;
    @(negedge clk);
    be2 = 0;
    repeat (2) @(negedge clk);
    chk("R11 stage stalls without enable", bq2, w18(1023));
    be2 = 1;
    @(negedge clk);
    chk("R11 stage advances with enable", bq2, w18(3));
    be2 = 0;
    for (int n = 0; n < 8192; n++) begin
      ae2 = 1; aw2 = 0; aa2 = 13'(n);
      @(negedge clk);
      chk("R4 narrow placement", aq2, nar(n));
    end
    chk("R2 last narrow address", aq2, m2[2047][7:6]);
    held = 18'(nar(8191));
    for (int n = 0; n < 8192; n++) begin
      aw2 = 1; aa2 = 13'(n); ad2 = 2'(n*3+1);
      @(negedge clk);
      chk("R8 hold on write", aq2, held);
      m2[n/4][(n%4)*2 +: 2] = ad2;
    end
    ae2 = 0; aw2 = 0;
    for (int j = 0; j < 1024; j++) begin
      be2 = 1; ba2 = 10'(j);
      @(negedge clk);
      if (j > 0) chk("R4 narrow writes keep bit 8", bq2, w18(j-1));
    end
    @(negedge clk);
    chk("R2 last 18-bit word", bq2, w18(1023));
    bw2 = 2'b10; ba2 = 3; bd2 = '1;
    oldw = w18(3);
    @(negedge clk);
    m2[7] = '1;
    bw2 = 0;
    @(negedge clk);
    chk("R7 old data through stage", bq2, oldw);
    @(negedge clk);
    chk("R10 upper lane only", bq2, w18(3));
    be2 = 0;

    done = 1;
    summary();
    $finish;
  end
endmodule